// File: doc/BRIEF.md
# Instruction Fetch Address Generator

This block produces the address of every instruction fetch in a three-stage fetch/decode/execute pipeline. A word-aligned address register drives the memory address bus. On each cycle that the pipeline advances, the register loads one of three values. The first is the current address plus four, from a dedicated incrementer. The second is a branch or program-counter-write target taken from the ALU result. The third is a fixed exception vector chosen by an exception code. Because the register always holds the address being fetched, the instruction in execute sits eight bytes lower.

A sequential hint tells the external memory controller that the address now on the bus is the previous fetch address plus four. The controller can then keep a DRAM page open and use a page-mode burst. A redirect to an ALU target or to a vector flushes the pipeline: both instructions already fetched are marked invalid. Two slot-valid outputs show refill after reset or a redirect. A stall input freezes all state while a multi-cycle instruction runs or memory is slow. An exception request is accepted only on a cycle that starts a new fetch.

Top module: `fetch_addr_gen`

## Requirements
- R1: While rst_ni is low, fetch_addr_o is 0, seq_o is 0 and slot_vld_o is 2'b00.
- R2: On a cycle with stall_i low, exc_i low and branch_i low, the next fetch_addr_o is the current one plus 4, modulo 2^ADDR_W, and seq_o is 1.
- R3: On a cycle with stall_i low, exc_i low and branch_i high, the next fetch_addr_o is branch_tgt_i with bits [1:0] cleared, and seq_o is 0.
- R4: On a cycle with stall_i low and exc_i high, the next fetch_addr_o is VEC_BASE + 4*exc_code_i, and seq_o is 0.
- R5: An exception request takes priority over a branch request in the same cycle.
- R6: While stall_i is high, fetch_addr_o, seq_o and slot_vld_o keep their values, and branch_i and exc_i have no effect.
- R7: Bits [1:0] of fetch_addr_o are always 0.
- R8: flush_o is high, in the same cycle, exactly when stall_i is low and exc_i or branch_i is high. In the next cycle slot_vld_o is 2'b00.
- R9: slot_vld_o bit 0 marks the decode slot and bit 1 the execute slot. On each non-stalled cycle without a flush, bit 1 takes the old bit 0 and bit 0 becomes 1. After a flush the sequence is 2'b00, 2'b01, 2'b11.
- R10: exc_ack_o is high, in the same cycle, exactly when exc_i is high and stall_i is low, which is the start of a new fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold all fetch state this cycle |
| branch_i | input | 1 | Load the ALU target as the next fetch address |
| branch_tgt_i | input | ADDR_W | ALU result used as the redirect target |
| exc_i | input | 1 | Exception request |
| exc_code_i | input | EXC_W | Exception type; selects the vector |
| fetch_addr_o | output | ADDR_W | Current instruction fetch address |
| seq_o | output | 1 | Current address equals the previous fetch address plus 4 |
| flush_o | output | 1 | Redirect this cycle; discard fetched instructions |
| exc_ack_o | output | 1 | Exception accepted this cycle |
| slot_vld_o | output | 2 | Valid flags of the decode (bit 0) and execute (bit 1) slots |

## Verification
The assertions check on every cycle that the address stays word aligned and that a stall freezes the address and the sequential hint. They also check that a plain advance gives address plus four with the hint set, that an accepted exception lands on its vector, and that a flush leaves empty slots and a non-sequential fetch in the next cycle. Other behaviours need the bench's scenarios. These are the priority of an exception over a simultaneous branch, wrap-around at the top of the address space, that stalled requests are dropped rather than deferred, and the exact 00, 01, 11 refill sequence of the slot flags. The bench covers them with a reference model driven by seeded random stimulus and directed cases.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INCR = 2'd1,
    SRC_ALU  = 2'd2,
    SRC_VEC  = 2'd3
  } fa_src_e;
endpackage

// File: rtl/fa_incr.sv
module fa_incr #(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned STEP   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = addr_i + ADDR_W'(STEP);
endmodule

// File: rtl/fa_next_sel.sv
module fa_next_sel
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned EXC_W    = 3,
  parameter int unsigned VEC_BASE = 0
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] inc_i,
  input  logic              stall_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              exc_i,
  input  logic [EXC_W-1:0]  code_i,
  output logic [ADDR_W-1:0] nxt_o,
  output fa_src_e           src_o
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] VBASE     = ADDR_W'(VEC_BASE) & WORD_MASK;

  logic [ADDR_W-1:0] vec_addr;
  assign vec_addr = VBASE + (ADDR_W'(code_i) << 2);

  always_comb begin
    if (stall_i) begin
      src_o = SRC_HOLD;
      nxt_o = cur_i;
    end else if (exc_i) begin
      src_o = SRC_VEC;
      nxt_o = vec_addr;
    end else if (branch_i) begin
      src_o = SRC_ALU;
      nxt_o = tgt_i & WORD_MASK;
    end else begin
      src_o = SRC_INCR;
      nxt_o = inc_i & WORD_MASK;
    end
  end
endmodule

// File: rtl/fa_slot_track.sv
module fa_slot_track #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             kill_i,
  output logic [DEPTH-1:0] vld_o
);
  logic [DEPTH-1:0] vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
      end else if (adv_i) begin
        if (kill_i) begin
          vld_q[g] <= 1'b0;
        end else if (g == 0) begin
          vld_q[g] <= 1'b1;
        end else begin
          vld_q[g] <= vld_q[g-1];
        end
      end
    end
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned EXC_W    = 3,
  parameter int unsigned VEC_BASE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] branch_tgt_i,
  input  logic              exc_i,
  input  logic [EXC_W-1:0]  exc_code_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              seq_o,
  output logic              flush_o,
  output logic              exc_ack_o,
  output logic [1:0]        slot_vld_o
);
  logic [ADDR_W-1:0] addr_q, addr_inc, addr_nxt;
  logic              seq_q;
  fa_src_e           src;
  logic              redirect;

  fa_incr #(.ADDR_W(ADDR_W), .STEP(4)) u_incr (
    .addr_i (addr_q),
    .addr_o (addr_inc)
  );

  fa_next_sel #(.ADDR_W(ADDR_W), .EXC_W(EXC_W), .VEC_BASE(VEC_BASE)) u_sel (
    .cur_i    (addr_q),
    .inc_i    (addr_inc),
    .stall_i  (stall_i),
    .branch_i (branch_i),
    .tgt_i    (branch_tgt_i),
    .exc_i    (exc_i),
    .code_i   (exc_code_i),
    .nxt_o    (addr_nxt),
    .src_o    (src)
  );

  assign redirect = (src == SRC_ALU) || (src == SRC_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      seq_q  <= 1'b0;
    end else if (src != SRC_HOLD) begin
      addr_q <= addr_nxt;
      seq_q  <= (src == SRC_INCR);
    end
  end

  fa_slot_track #(.DEPTH(2)) u_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (src != SRC_HOLD),
    .kill_i (redirect),
    .vld_o  (slot_vld_o)
  );

  assign fetch_addr_o = addr_q;
  assign seq_o        = seq_q;
  assign flush_o      = redirect;
  assign exc_ack_o    = (src == SRC_VEC);
endmodule

// File: rtl/fetch_addr_gen_chk.sv
module fetch_addr_gen_chk #(
  parameter int unsigned ADDR_W   = 26,
  parameter int unsigned EXC_W    = 3,
  parameter int unsigned VEC_BASE = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              exc_i,
  input logic [EXC_W-1:0]  exc_code_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              seq_o,
  input logic              flush_o,
  input logic              exc_ack_o,
  input logic [1:0]        slot_vld_o
);
  localparam logic [ADDR_W-1:0] VB = ADDR_W'(VEC_BASE) & ~ADDR_W'(3);

  p_word_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_addr_o[1:0] == 2'b00);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(fetch_addr_o) && $stable(seq_o) && $stable(slot_vld_o));

  p_incr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !flush_o) |=> seq_o && (fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(4)));

  p_vector_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ack_o |=> fetch_addr_o == VB + (ADDR_W'($past(exc_code_i)) << 2));

  p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !seq_o && slot_vld_o == 2'b00);

  p_ack_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_ack_o |-> exc_i && !stall_i && flush_o);
endmodule

bind fetch_addr_gen fetch_addr_gen_chk #(
  .ADDR_W(ADDR_W), .EXC_W(EXC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .exc_i        (exc_i),
  .exc_code_i   (exc_code_i),
  .fetch_addr_o (fetch_addr_o),
  .seq_o        (seq_o),
  .flush_o      (flush_o),
  .exc_ack_o    (exc_ack_o),
  .slot_vld_o   (slot_vld_o)
);

// File: tb/fetch_addr_gen_tb_top.sv
module fetch_addr_gen_tb_top;
  localparam int unsigned AW = 26;
  localparam int unsigned EW = 3;
  localparam logic [AW-1:0] WMASK = ~AW'(3);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stall_i = 1'b0, branch_i = 1'b0, exc_i = 1'b0;
  logic [AW-1:0] branch_tgt_i = '0;
  logic [EW-1:0] exc_code_i = '0;
  logic [AW-1:0] fetch_addr_o;
  logic          seq_o, flush_o, exc_ack_o;
  logic [1:0]    slot_vld_o;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_addr = '0;
  logic          m_seq = 1'b0;
  logic [1:0]    m_vld = 2'b00;

  always #2.5 clk_i = ~clk_i;

  fetch_addr_gen #(.ADDR_W(AW), .EXC_W(EW), .VEC_BASE(0)) dut_i (
    .clk_i, .rst_ni, .stall_i, .branch_i, .branch_tgt_i, .exc_i, .exc_code_i,
    .fetch_addr_o, .seq_o, .flush_o, .exc_ack_o, .slot_vld_o
  );

  function automatic logic [AW-1:0] f_next(input logic [AW-1:0] cur, input logic st,
      input logic br, input logic [AW-1:0] tg, input logic ex, input logic [EW-1:0] cd);
    if (st) return cur;
    if (ex) return AW'(cd) * AW'(4);
    if (br) return tg & WMASK;
    return cur + AW'(4);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(fetch_addr_o == m_addr, {req, " addr"}, fetch_addr_o, m_addr);
    chk(seq_o == m_seq, {req, " seq"}, AW'(seq_o), AW'(m_seq));
    chk(slot_vld_o == m_vld, {req, " slots"}, AW'(slot_vld_o), AW'(m_vld));
    chk(fetch_addr_o[1:0] == 2'b00, "R7 align", fetch_addr_o, fetch_addr_o & WMASK);
  endtask

  // drive at negedge, check comb outputs, advance model, check state at next negedge
  task automatic step(input logic st, input logic br, input logic [AW-1:0] tg,
                      input logic ex, input logic [EW-1:0] cd, input string req);
    logic red;
    stall_i = st; branch_i = br; branch_tgt_i = tg; exc_i = ex; exc_code_i = cd;
    #1;
    red = !st && (ex || br);
    chk(flush_o == red, "R8 flush", AW'(flush_o), AW'(red));
    chk(exc_ack_o == (ex && !st), "R10 ack", AW'(exc_ack_o), AW'(ex && !st));
    if (!st) begin
      m_addr = f_next(m_addr, st, br, tg, ex, cd);
      m_seq  = !red;
      m_vld  = red ? 2'b00 : {m_vld[0], 1'b1};
    end
    @(negedge clk_i);
    chk_state(req);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [AW-1:0] a0;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk_state("R1 reset");
    rst_ni = 1'b1;
    // R2 sequential run
    repeat (4) step(0, 0, '0, 0, '0, "R2 incr");
    // R3 branch with unaligned target, then R9 refill
    step(0, 1, AW'(26'h12_3457), 0, '0, "R3 branch");
    step(0, 0, '0, 0, '0, "R9 refill 01");
    step(0, 0, '0, 0, '0, "R9 refill 11");
    // R6 stall ignores requests
    a0 = fetch_addr_o;
    step(1, 1, AW'(26'h100), 1, 3'd5, "R6 stall");
    chk(fetch_addr_o == a0, "R6 no effect", fetch_addr_o, a0);
    step(1, 0, '0, 0, '0, "R6 stall");
    // R4 / R5 exception beats branch
    step(0, 1, AW'(26'h200), 1, 3'd6, "R5 prio");
    chk(fetch_addr_o == AW'(24), "R4 vec", fetch_addr_o, AW'(24));
    step(0, 0, '0, 1, 3'd7, "R4 vec7");
    // R2 wrap at top of address space
    step(0, 1, {AW{1'b1}}, 0, '0, "R3 top");
    step(0, 0, '0, 0, '0, "R2 wrap");
    chk(fetch_addr_o == '0, "R2 wrap zero", fetch_addr_o, '0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic st, br, ex;
      st = ($urandom % 100) < 20;
      ex = ($urandom % 100) < 6;
      br = ($urandom % 100) < 15;
      step(st, br, AW'($urandom), ex, EW'($urandom), "R2 R3 R4 R6 R9 rand");
    end
    // R1 async reset mid-run
    #1 rst_ni = 1'b0;
    m_addr = '0; m_seq = 1'b0; m_vld = 2'b00;
    #1 chk_state("R1 reset");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule